// File: doc/BRIEF.md
# Four-Phase FSK Symbol Deinterleaver

This block sits in the data window of a paging receiver frame. Timing recovery supplies one centre-sampled 2-bit FSK level per bit period. The deinterleaver turns each level into bits on four parallel phase streams, named A, B, C and D. It hands the four bits to the code-word assembler as one registered beat, marked by a single-cycle valid strobe.

Two mode inputs set how levels become bits. The level-count select chooses between one bit per symbol (2-level) and a Gray-coded dibit (4-level). The baud select chooses between one symbol per output beat (1600 baud) and two symbols per beat (3200 baud). At 3200 baud, consecutive symbols alternate between the A/B pair and the C/D pair, and a beat is emitted only after the second symbol. Phases that the current mode never writes keep the idle value 0. The frame controller drives two inputs. One clears everything whenever it falls back to idle. The other marks the start of a data window, so that every frame begins on the A/B half.

Top module: `fsk_phase_deint`

## Requirements
- R1: The A (or C) bit taken from a symbol is 1 when the symbol value is 0 or 1, and 0 when it is 2 or 3; phase bit 0 carries A, bit 1 B, bit 2 C, bit 3 D.
- R2: With `levels_sel`=1 (4-level), the B (or D) bit is 1 for symbol values 0 and 3 and 0 for values 1 and 2, so the symbols 0,1,2,3 map to A/B pairs 11,10,00,01.
- R3: With `levels_sel`=0 (2-level), B and D are never written and keep the value they had, which is 0 after an idle clear.
- R4: With `baud_sel`=0 (1600 baud), every accepted symbol writes A (and B), and the cycle after it `out_valid` is 1 and `phase` carries all four held bits; C and D are not written.
- R5: With `baud_sel`=1 (3200 baud), accepted symbols alternate halves: a first-half symbol writes A/B and produces no beat; a second-half symbol writes C/D, and the next cycle `out_valid` is 1 with all four bits.
- R6: `idle_clr` clears the four held bits, the half toggle and `phase` (visible the next cycle, with `out_valid` 0), and it overrides `sym_valid` in the same cycle.
- R7: `win_start` resets the half toggle so that a symbol accepted in the same cycle, or the first one after it, is a first-half (A/B) symbol.
- R8: While `rst_n` is low, `phase` is 0 and `out_valid` is 0.
- R9: `out_valid` is a one-cycle pulse that is high only in the cycle after a symbol accepted with `sym_valid`=1 and `idle_clr`=0.
- R10: Between beats, `phase` holds its last value unless an idle clear intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_clr | input | 1 | Frame controller returned to idle: clear all state |
| win_start | input | 1 | Data window begins: restart at the A/B half |
| sym_valid | input | 1 | `symbol` holds a centre-sampled level |
| symbol | input | 2 | FSK level 0..3 |
| baud_sel | input | 1 | 0 = 1600 baud, 1 = 3200 baud |
| levels_sel | input | 1 | 0 = 2-level, 1 = 4-level |
| phase | output | 4 | Registered phase bits {D,C,B,A} of the last beat |
| out_valid | output | 1 | One-cycle strobe marking a new beat on `phase` |

## Verification
Each result appears exactly one register stage after the clock edge that samples the causing inputs. A beat, an idle clear or a suppressed first-half symbol therefore shows up on `phase` and `out_valid` in the very next cycle. The bench drives the inputs 2 ns after a rising edge and applies the same input set to its model at the following edge. It compares 2 ns after that edge, so each comparison falls in the one cycle where the result is due. At 3200 baud no beat is due after the first symbol of a pair, and the bench checks that `out_valid` is low in that cycle.

// File: rtl/fsk_deint_pkg.sv
package fsk_deint_pkg;

  localparam int SYM_W   = 2;
  localparam int N_PHASE = 4;

  localparam int PH_A = 0;
  localparam int PH_B = 1;
  localparam int PH_C = 2;
  localparam int PH_D = 3;

  typedef logic [SYM_W-1:0]   sym_t;
  typedef logic [N_PHASE-1:0] phase_t;

  // First bit of a symbol: high for the two lowest levels.
  function automatic logic first_bit(input sym_t s);
    return (s < sym_t'(2));
  endfunction

  // Second bit of a symbol (4-level Gray code): high for the outer levels.
  function automatic logic gray_bit(input sym_t s);
    return (s == sym_t'(0)) || (s == sym_t'(3));
  endfunction

endpackage

// File: rtl/fsk_dibit_map.sv
module fsk_dibit_map
  import fsk_deint_pkg::*;
(
  input  sym_t symbol,
  output logic bit_first,
  output logic bit_gray
);
  always_comb begin
    bit_first = first_bit(symbol);
    bit_gray  = gray_bit(symbol);
  end
endmodule

// File: rtl/fsk_half_track.sv
module fsk_half_track (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_clr,
  input  logic win_start,
  input  logic advance,
  output logic cur_half
);
  logic half_q;

  always_comb begin
    cur_half = win_start ? 1'b0 : half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
    end else if (idle_clr) begin
      half_q <= 1'b0;
    end else if (advance) begin
      half_q <= ~cur_half;
    end else begin
      half_q <= cur_half;
    end
  end
endmodule

// File: rtl/fsk_phase_bank.sv
module fsk_phase_bank
  import fsk_deint_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   idle_clr,
  input  logic   write_ab,
  input  logic   write_cd,
  input  logic   write_gray,
  input  logic   emit,
  input  logic   bit_first,
  input  logic   bit_gray,
  output phase_t hold,
  output phase_t phase,
  output logic   out_valid
);
  phase_t hold_n;

  always_comb begin
    hold_n = hold;
    if (write_ab) begin
      hold_n[PH_A] = bit_first;
      if (write_gray) hold_n[PH_B] = bit_gray;
    end
    if (write_cd) begin
      hold_n[PH_C] = bit_first;
      if (write_gray) hold_n[PH_D] = bit_gray;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      phase     <= '0;
      out_valid <= 1'b0;
    end else if (idle_clr) begin
      hold      <= '0;
      phase     <= '0;
      out_valid <= 1'b0;
    end else begin
      hold      <= hold_n;
      out_valid <= emit;
      if (emit) phase <= hold_n;
    end
  end
endmodule

// File: rtl/fsk_phase_deint.sv
module fsk_phase_deint
  import fsk_deint_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_clr,
  input  logic       win_start,
  input  logic       sym_valid,
  input  logic [1:0] symbol,
  input  logic       baud_sel,
  input  logic       levels_sel,
  output logic [3:0] phase,
  output logic       out_valid
);
  // Named internal events, brought out for the checker.
  logic   take;
  logic   fast_take;
  logic   cur_half;
  logic   write_ab;
  logic   write_cd;
  logic   emit;
  logic   bit_first;
  logic   bit_gray;
  phase_t hold;

  always_comb begin
    take      = sym_valid & ~idle_clr;
    fast_take = take & baud_sel;
    write_ab  = take & (~baud_sel | ~cur_half);
    write_cd  = fast_take & cur_half;
    emit      = take & (~baud_sel | cur_half);
  end

  fsk_dibit_map u_map (
    .symbol    (symbol),
    .bit_first (bit_first),
    .bit_gray  (bit_gray)
  );

  fsk_half_track u_half (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_clr  (idle_clr),
    .win_start (win_start),
    .advance   (fast_take),
    .cur_half  (cur_half)
  );

  fsk_phase_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_clr   (idle_clr),
    .write_ab   (write_ab),
    .write_cd   (write_cd),
    .write_gray (levels_sel),
    .emit       (emit),
    .bit_first  (bit_first),
    .bit_gray   (bit_gray),
    .hold       (hold),
    .phase      (phase),
    .out_valid  (out_valid)
  );
endmodule

// File: rtl/fsk_phase_deint_chk.sv
module fsk_phase_deint_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       idle_clr,
  input logic       win_start,
  input logic       baud_sel,
  input logic       levels_sel,
  input logic [1:0] symbol,
  input logic       take,
  input logic       cur_half,
  input logic [3:0] hold,
  input logic [3:0] phase,
  input logic       out_valid
);
  assert_map_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(baud_sel)) |-> (phase[0] == ($past(symbol) < 2'd2)));

  assert_gray_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(baud_sel) && $past(levels_sel))
      |-> (phase[1] == ($past(symbol[1]) == $past(symbol[0]))));

  assert_two_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !levels_sel) |=> ($stable(hold[1]) && $stable(hold[3])));

  assert_slow_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !baud_sel) |=> out_valid);

  assert_first_half_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && baud_sel && !cur_half) |=> !out_valid);

  assert_second_half_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && baud_sel && cur_half) |=> out_valid);

  assert_idle_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_clr |=> (phase == 4'd0 && hold == 4'd0 && !out_valid));

  assert_window_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |-> !cur_half);

  assert_valid_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(take));

  assert_phase_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !$past(idle_clr)) |-> $stable(phase));
endmodule

bind fsk_phase_deint fsk_phase_deint_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .idle_clr   (idle_clr),
  .win_start  (win_start),
  .baud_sel   (baud_sel),
  .levels_sel (levels_sel),
  .symbol     (symbol),
  .take       (take),
  .cur_half   (cur_half),
  .hold       (hold),
  .phase      (phase),
  .out_valid  (out_valid)
);

// File: tb/fsk_phase_deint_test.sv
`timescale 1ns/1ps
module fsk_phase_deint_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       idle_clr, win_start, sym_valid, baud_sel, levels_sel;
  logic [1:0] symbol;
  logic [3:0] phase;
  logic       out_valid;

  int checks = 0;
  int fails  = 0;

  // Bench model state
  logic [3:0] m_hold;
  logic [3:0] m_phase;
  logic       m_valid;
  logic       m_half;

  always #4 clk = ~clk;

  fsk_phase_deint uut (
    .clk(clk), .rst_n(rst_n), .idle_clr(idle_clr), .win_start(win_start),
    .sym_valid(sym_valid), .symbol(symbol), .baud_sel(baud_sel),
    .levels_sel(levels_sel), .phase(phase), .out_valid(out_valid)
  );

  function automatic logic ref_a(input logic [1:0] s);
    return ~s[1];
  endfunction

  function automatic logic ref_b(input logic [1:0] s);
    return ~(s[1] ^ s[0]);
  endfunction

  task automatic check(input string tag, input logic [3:0] exp_ph, input logic exp_v);
    checks++;
    if (phase !== exp_ph || out_valid !== exp_v) begin
      fails++;
      $display("FAIL %s: phase=%b out_valid=%b expected phase=%b out_valid=%b",
               tag, phase, out_valid, exp_ph, exp_v);
    end
  endtask

  task automatic model_edge();
    logic second;
    logic beat;
    if (idle_clr) begin
      m_hold = '0; m_phase = '0; m_valid = 1'b0; m_half = 1'b0;
    end else begin
      if (win_start) m_half = 1'b0;
      beat = 1'b0;
      if (sym_valid) begin
        second = baud_sel && m_half;
        if (!second) begin
          m_hold[0] = ref_a(symbol);
          if (levels_sel) m_hold[1] = ref_b(symbol);
        end else begin
          m_hold[2] = ref_a(symbol);
          if (levels_sel) m_hold[3] = ref_b(symbol);
        end
        if (baud_sel) m_half = ~m_half;
        beat = !baud_sel || second;
      end
      m_valid = beat;
      if (beat) m_phase = m_hold;
    end
  endtask

  task automatic step(input logic v, input logic [1:0] s, input logic b, input logic l,
                      input logic st, input logic idl, input string tag);
    sym_valid = v; symbol = s; baud_sel = b; levels_sel = l;
    win_start = st; idle_clr = idl;
    @(posedge clk);
    model_edge();
    #2;
    check(tag, m_phase, m_valid);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; idle_clr = 1'b0; win_start = 1'b0; sym_valid = 1'b1;
    symbol = 2'd0; baud_sel = 1'b0; levels_sel = 1'b1;
    m_hold = '0; m_phase = '0; m_valid = 1'b0; m_half = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset state", 4'b0000, 1'b0);
    sym_valid = 1'b0;
    #2 rst_n = 1'b1;

    // R1 R2 R4: 1600 baud, 4-level, every level
    step(0, 2'd0, 0, 1, 1, 0, "R7 window start idle");
    step(1, 2'd0, 0, 1, 0, 0, "R1 R2 R4 level0 -> A1 B1");
    step(1, 2'd1, 0, 1, 0, 0, "R1 R2 R4 level1 -> A1 B0");
    step(1, 2'd2, 0, 1, 0, 0, "R1 R2 R4 level2 -> A0 B0");
    step(1, 2'd3, 0, 1, 0, 0, "R1 R2 R4 level3 -> A0 B1");
    step(0, 2'd0, 0, 1, 0, 0, "R9 R10 gap holds beat");
    step(0, 2'd2, 0, 1, 0, 0, "R10 gap holds beat");

    // R6: idle clear wins over a valid symbol
    step(1, 2'd0, 0, 1, 0, 1, "R6 idle clear overrides symbol");

    // R3: 2-level leaves B at 0
    step(1, 2'd0, 0, 0, 1, 0, "R3 2-level level0 -> A only");
    step(1, 2'd3, 0, 0, 0, 0, "R3 2-level level3 B stays 0");

    // R5: 3200 baud pairs, 4-level
    step(0, 2'd0, 1, 1, 0, 1, "R6 clear before fast mode");
    step(1, 2'd1, 1, 1, 1, 0, "R5 R7 first half silent");
    step(1, 2'd3, 1, 1, 0, 0, "R5 second half beat");
    step(1, 2'd2, 1, 1, 0, 0, "R5 next first half silent");
    step(0, 2'd0, 1, 1, 0, 0, "R10 hold mid pair");
    step(1, 2'd0, 1, 1, 0, 0, "R5 second half after gap");

    // R7: window start in the middle of a pair restarts at A/B
    step(1, 2'd2, 1, 1, 0, 0, "R5 first half");
    step(1, 2'd0, 1, 1, 1, 0, "R7 restart makes this a first half");
    step(1, 2'd1, 1, 1, 0, 0, "R7 beat after restart");

    // R3 at 3200 baud
    step(0, 2'd0, 1, 0, 0, 1, "R6 clear");
    step(1, 2'd3, 1, 0, 1, 0, "R3 fast 2-level first half");
    step(1, 2'd0, 1, 0, 0, 0, "R3 fast 2-level B D stay 0");

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic v, b, l, st, idl;
      logic [1:0] s;
      v   = ($urandom % 4) != 0;
      s   = 2'($urandom);
      st  = ($urandom % 32) == 0;
      idl = ($urandom % 64) == 0;
      b   = (n / 500) % 2 == 1;
      l   = (n / 250) % 2 == 0;
      step(v, s, b, l, st, idl, "R1 R2 R3 R4 R5 R6 R7 R9 R10 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule